// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steers a multicycle load/store datapath from a read-only microprogram store. A micro-address register selects one microinstruction word per clock. The word is split into the control fields the datapath consumes: ALU operation, first and second operand source, register-file action, memory action and PC update. It also carries a two-bit sequencing code. The sequencing code picks the next micro-address. It can step to the following word, return to the fetch routine, or look up one of two opcode-indexed dispatch tables.

The datapath feeds in the 6-bit opcode of the instruction it holds. The block returns the control fields for the current cycle together with the current micro-address. If a dispatch lookup finds no entry for the opcode, the block raises an illegal-opcode flag for that cycle and sends control back to fetch. The opcode values, the microprogram layout and the output staging are parameters of the block.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `upc_o` is 0. A reset asserted in the middle of a routine abandons it.
- R2: Micro-address 0 (fetch) emits alu 00 (add), src1 0 (PC), src2 01 (constant four), reg 00 (none), mem 01 (read at PC), pc 01 (write ALU result) and seq 00.
- R3: Sequencing code 00 advances the micro-address by one. Micro-address 1 (decode) emits alu 00, src1 0, src2 11 (shifted sign-extended offset), seq 10, and every other field 0.
- R4: Sequencing code 10 consults the first dispatch table. Opcodes 0x23 (load) and 0x2B (store) go to 2, opcode 0x00 (register format) goes to 6, opcode 0x04 (branch-equal) goes to 8, and opcode 0x02 (jump) goes to 9.
- R5: Sequencing code 11 consults the second dispatch table: load goes to 3 and store goes to 5. Micro-address 2 emits alu 00, src1 1 (A), src2 10 (sign-extended), seq 11, and zeros elsewhere.
- R6: Load path. Address 3 emits mem 10 (read at ALUout) with seq 00. Address 4 emits reg 10 (write MDR) with seq 01. All other fields are 0.
- R7: Store path. Address 5 emits mem 11 (write at ALUout) with seq 01. All other fields are 0.
- R8: Register-format path. Address 6 emits alu 10 (function code), src1 1, src2 00 (B) with seq 00. Address 7 emits reg 01 (write ALUout) with seq 01. All other fields are 0.
- R9: Address 8 emits alu 01 (subtract), src1 1, src2 00, pc 10 (conditional write from ALUout) with seq 01. Address 9 emits pc 11 (jump target) with seq 01. All other fields are 0.
- R10: Sequencing code 01 makes the next micro-address 0.
- R11: An opcode missing from the first dispatch table raises `illegal_op_o` in the decode cycle, and the next micro-address is 0. In every cycle with no lookup miss, `illegal_op_o` is low.
- R12: An opcode missing from the second dispatch table also raises `illegal_op_o` and returns to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | OPC_W (6) | Opcode of the instruction held by the datapath |
| upc_o | output | UADDR_W (4) | Current micro-address |
| alu_op_o | output | 2 | ALU operation select |
| src1_sel_o | output | 1 | First operand source |
| src2_sel_o | output | 2 | Second operand source |
| reg_ctl_o | output | 2 | Register-file action |
| mem_ctl_o | output | 2 | Memory action |
| pc_ctl_o | output | 2 | PC update select |
| seq_o | output | 2 | Sequencing code of the current word |
| illegal_op_o | output | 1 | Dispatch lookup miss in this cycle |

## Verification
The hardest case to reach is a miss in the second dispatch table. That table is only consulted from the memory-address word, and the first table sends only load and store opcodes there, so a steady opcode never misses it. The stimulus sends a load opcode through decode. Once the sequencer sits at micro-address 2, it switches the opcode to an unmapped value. The bench then expects the flag in that same cycle and a clean fetch afterwards. A reset asserted in the middle of a load routine is driven the same way, by timing the stimulus against the expected micro-address.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUNCT = 2'b10} alu_e;
   typedef enum logic {S1_PC = 1'b0, S1_A = 1'b1} src1_e;
   typedef enum logic [1:0] {S2_B = 2'b00, S2_FOUR = 2'b01, S2_SEXT = 2'b10, S2_SEXT_SH = 2'b11} src2_e;
   typedef enum logic [1:0] {RG_NONE = 2'b00, RG_WR_ALU = 2'b01, RG_WR_MDR = 2'b10} reg_e;
   typedef enum logic [1:0] {MM_NONE = 2'b00, MM_RD_PC = 2'b01, MM_RD_ALU = 2'b10, MM_WR_ALU = 2'b11} mem_e;
   typedef enum logic [1:0] {PC_NONE = 2'b00, PC_ALU = 2'b01, PC_COND = 2'b10, PC_JUMP = 2'b11} pc_e;
   typedef enum logic [1:0] {SQ_NEXT = 2'b00, SQ_FETCH = 2'b01, SQ_DISP1 = 2'b10, SQ_DISP2 = 2'b11} seq_e;

   typedef struct packed {
      alu_e  alu;
      src1_e src1;
      src2_e src2;
      reg_e  rg;
      mem_e  mem;
      pc_e   pc;
      seq_e  seq;
   } uword_t;

   localparam int UWORD_W = $bits(uword_t);

   // Microprogram layout; the dispatch tables and the fetch return point depend on it.
   localparam int UA_FETCH  = 0;
   localparam int UA_DECODE = 1;
   localparam int UA_MEM1   = 2;
   localparam int UA_LW2    = 3;
   localparam int UA_LW3    = 4;
   localparam int UA_SW2    = 5;
   localparam int UA_RF1    = 6;
   localparam int UA_RF2    = 7;
   localparam int UA_BEQ1   = 8;
   localparam int UA_JMP1   = 9;
   localparam int UA_COUNT  = 10;

   // Contents of one microprogram word; unlisted addresses idle and return to fetch.
   function automatic uword_t ucode_word(int unsigned a);
      uword_t w;
      w = '{alu: ALU_ADD, src1: S1_PC, src2: S2_B, rg: RG_NONE,
            mem: MM_NONE, pc: PC_NONE, seq: SQ_FETCH};
      case (a)
         UA_FETCH: begin
            w.src2 = S2_FOUR;
            w.mem  = MM_RD_PC;
            w.pc   = PC_ALU;
            w.seq  = SQ_NEXT;
         end
         UA_DECODE: begin
            w.src2 = S2_SEXT_SH;
            w.seq  = SQ_DISP1;
         end
         UA_MEM1: begin
            w.src1 = S1_A;
            w.src2 = S2_SEXT;
            w.seq  = SQ_DISP2;
         end
         UA_LW2: begin
            w.mem = MM_RD_ALU;
            w.seq = SQ_NEXT;
         end
         UA_LW3:  w.rg  = RG_WR_MDR;
         UA_SW2:  w.mem = MM_WR_ALU;
         UA_RF1: begin
            w.alu  = ALU_FUNCT;
            w.src1 = S1_A;
            w.seq  = SQ_NEXT;
         end
         UA_RF2:  w.rg = RG_WR_ALU;
         UA_BEQ1: begin
            w.alu  = ALU_SUB;
            w.src1 = S1_A;
            w.pc   = PC_COND;
         end
         UA_JMP1: w.pc = PC_JUMP;
         default: ;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
   import useq_pkg::*;
#(
   parameter int UADDR_W = 4
) (
   input  logic [UADDR_W-1:0] raddr,
   output uword_t             rdata
);
   localparam int DEPTH = 1 << UADDR_W;

   uword_t store [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_word
      assign store[a] = ucode_word(a);
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
   import useq_pkg::*;
#(
   parameter int               OPC_W      = 6,
   parameter int               UADDR_W    = 4,
   parameter logic [OPC_W-1:0] OPC_RTYPE  = 6'h00,
   parameter logic [OPC_W-1:0] OPC_LOAD   = 6'h23,
   parameter logic [OPC_W-1:0] OPC_STORE  = 6'h2B,
   parameter logic [OPC_W-1:0] OPC_BRANCH = 6'h04,
   parameter logic [OPC_W-1:0] OPC_JUMP   = 6'h02
) (
   input  logic [OPC_W-1:0]   opcode,
   output logic               hit1,
   output logic [UADDR_W-1:0] tgt1,
   output logic               hit2,
   output logic [UADDR_W-1:0] tgt2
);
   // First table: opcode class to routine entry.
   always_comb begin
      hit1 = 1'b1;
      tgt1 = UADDR_W'(UA_FETCH);
      if (opcode == OPC_LOAD || opcode == OPC_STORE) tgt1 = UADDR_W'(UA_MEM1);
      else if (opcode == OPC_RTYPE)                  tgt1 = UADDR_W'(UA_RF1);
      else if (opcode == OPC_BRANCH)                 tgt1 = UADDR_W'(UA_BEQ1);
      else if (opcode == OPC_JUMP)                   tgt1 = UADDR_W'(UA_JMP1);
      else                                           hit1 = 1'b0;
   end

   // Second table: memory direction.
   always_comb begin
      hit2 = 1'b1;
      tgt2 = UADDR_W'(UA_FETCH);
      if (opcode == OPC_LOAD)       tgt2 = UADDR_W'(UA_LW2);
      else if (opcode == OPC_STORE) tgt2 = UADDR_W'(UA_SW2);
      else                          hit2 = 1'b0;
   end
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int UADDR_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  seq_e               seq,
   input  logic               hit1,
   input  logic [UADDR_W-1:0] tgt1,
   input  logic               hit2,
   input  logic [UADDR_W-1:0] tgt2,
   output logic [UADDR_W-1:0] upc_q,
   output logic [UADDR_W-1:0] nxt,
   output logic               miss
);
   localparam logic [UADDR_W-1:0] FETCH_A = UADDR_W'(UA_FETCH);

   always_comb begin
      miss = 1'b0;
      unique case (seq)
         SQ_NEXT:  nxt = upc_q + UADDR_W'(1);
         SQ_FETCH: nxt = FETCH_A;
         SQ_DISP1: begin
            nxt  = hit1 ? tgt1 : FETCH_A;
            miss = !hit1;
         end
         SQ_DISP2: begin
            nxt  = hit2 ? tgt2 : FETCH_A;
            miss = !hit2;
         end
         default:  nxt = FETCH_A;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) upc_q <= FETCH_A;
      else     upc_q <= nxt;
   end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
   import useq_pkg::*;
#(
   parameter int               UADDR_W    = 4,
   parameter int               OPC_W      = 6,
   parameter bit               OUT_REG    = 1'b0,
   parameter logic [OPC_W-1:0] OPC_RTYPE  = 6'h00,
   parameter logic [OPC_W-1:0] OPC_LOAD   = 6'h23,
   parameter logic [OPC_W-1:0] OPC_STORE  = 6'h2B,
   parameter logic [OPC_W-1:0] OPC_BRANCH = 6'h04,
   parameter logic [OPC_W-1:0] OPC_JUMP   = 6'h02
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [OPC_W-1:0]   opcode_i,
   output logic [UADDR_W-1:0] upc_o,
   output logic [1:0]         alu_op_o,
   output logic               src1_sel_o,
   output logic [1:0]         src2_sel_o,
   output logic [1:0]         reg_ctl_o,
   output logic [1:0]         mem_ctl_o,
   output logic [1:0]         pc_ctl_o,
   output logic [1:0]         seq_o,
   output logic               illegal_op_o
);
   localparam int DEPTH = 1 << UADDR_W;

   if (DEPTH < UA_COUNT) begin : g_chk_depth
      $error("ucode_sequencer: UADDR_W too small for the microprogram");
   end
   if (OPC_W < 1) begin : g_chk_opc
      $error("ucode_sequencer: OPC_W must be positive");
   end
   if (OPC_LOAD == OPC_STORE || OPC_LOAD == OPC_RTYPE || OPC_LOAD == OPC_BRANCH ||
       OPC_LOAD == OPC_JUMP || OPC_STORE == OPC_RTYPE || OPC_STORE == OPC_BRANCH ||
       OPC_STORE == OPC_JUMP || OPC_RTYPE == OPC_BRANCH || OPC_RTYPE == OPC_JUMP ||
       OPC_BRANCH == OPC_JUMP) begin : g_chk_uniq
      $error("ucode_sequencer: dispatch opcodes must be distinct");
   end

   uword_t             cur;
   uword_t             rom_q;
   logic [UADDR_W-1:0] rom_a;
   logic               hit1, hit2, miss;
   logic [UADDR_W-1:0] tgt1, tgt2, upc_q, nxt;

   useq_dispatch #(
      .OPC_W(OPC_W), .UADDR_W(UADDR_W),
      .OPC_RTYPE(OPC_RTYPE), .OPC_LOAD(OPC_LOAD), .OPC_STORE(OPC_STORE),
      .OPC_BRANCH(OPC_BRANCH), .OPC_JUMP(OPC_JUMP)
   ) disp_i (
      .opcode(opcode_i), .hit1(hit1), .tgt1(tgt1), .hit2(hit2), .tgt2(tgt2)
   );

   useq_next #(.UADDR_W(UADDR_W)) next_i (
      .clk(clk), .rst(rst), .seq(cur.seq),
      .hit1(hit1), .tgt1(tgt1), .hit2(hit2), .tgt2(tgt2),
      .upc_q(upc_q), .nxt(nxt), .miss(miss)
   );

   useq_rom #(.UADDR_W(UADDR_W)) rom_i (.raddr(rom_a), .rdata(rom_q));

   if (OUT_REG) begin : g_staged
      // Word for the coming address is read ahead and held in a register.
      uword_t word_q;
      assign rom_a = rst ? UADDR_W'(UA_FETCH) : nxt;
      always_ff @(posedge clk) word_q <= rom_q;
      assign cur = word_q;
   end else begin : g_direct
      assign rom_a = upc_q;
      assign cur   = rom_q;
   end

   assign upc_o        = upc_q;
   assign alu_op_o     = cur.alu;
   assign src1_sel_o   = cur.src1;
   assign src2_sel_o   = cur.src2;
   assign reg_ctl_o    = cur.rg;
   assign mem_ctl_o    = cur.mem;
   assign pc_ctl_o     = cur.pc;
   assign seq_o        = cur.seq;
   assign illegal_op_o = miss;
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
   parameter int UADDR_W = 4
) (
   input logic               clk,
   input logic               rst,
   input logic [UADDR_W-1:0] upc,
   input logic [1:0]         seq,
   input logic [1:0]         alu,
   input logic [1:0]         mem,
   input logic [1:0]         pc,
   input logic               illegal
);
   p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> upc == '0);

   p_fetch_word_r2: assert property (@(posedge clk) disable iff (rst)
      upc == '0 |-> mem == 2'b01 && pc == 2'b01 && seq == 2'b00);

   p_step_incr_r3: assert property (@(posedge clk) disable iff (rst)
      seq == 2'b00 |=> upc == $past(upc) + UADDR_W'(1));

   p_disp1_target_r4: assert property (@(posedge clk) disable iff (rst)
      seq == 2'b10 && !illegal |=> upc == UADDR_W'(2) || upc == UADDR_W'(6) ||
                                   upc == UADDR_W'(8) || upc == UADDR_W'(9));

   p_disp2_target_r5: assert property (@(posedge clk) disable iff (rst)
      seq == 2'b11 && !illegal |=> upc == UADDR_W'(3) || upc == UADDR_W'(5));

   p_branch_word_r9: assert property (@(posedge clk) disable iff (rst)
      upc == UADDR_W'(8) |-> alu == 2'b01 && pc == 2'b10);

   p_fetch_return_r10: assert property (@(posedge clk) disable iff (rst)
      seq == 2'b01 |=> upc == '0);

   p_miss_to_fetch_r11: assert property (@(posedge clk) disable iff (rst)
      illegal |=> upc == '0);

   p_miss_only_dispatch_r12: assert property (@(posedge clk) disable iff (rst)
      illegal |-> seq[1]);
endmodule

bind ucode_sequencer useq_checker #(.UADDR_W(UADDR_W)) chk_i (
   .clk(clk), .rst(rst), .upc(upc_o), .seq(seq_o), .alu(alu_op_o),
   .mem(mem_ctl_o), .pc(pc_ctl_o), .illegal(illegal_op_o)
);

// File: tb/ucode_sequencer_tb_top.sv
module ucode_sequencer_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opc = 6'h00;
   logic [3:0] upc;
   logic [1:0] alu, src2, rg, mem, pc, seq;
   logic       src1, ill;

   localparam logic [5:0] OP_LW = 6'h23, OP_SW = 6'h2B, OP_R = 6'h00,
                          OP_BEQ = 6'h04, OP_J = 6'h02, OP_BAD = 6'h3F, OP_BAD2 = 6'h01;

   always #2 clk = ~clk;

   ucode_sequencer dut_i (
      .clk(clk), .rst(rst), .opcode_i(opc), .upc_o(upc), .alu_op_o(alu),
      .src1_sel_o(src1), .src2_sel_o(src2), .reg_ctl_o(rg), .mem_ctl_o(mem),
      .pc_ctl_o(pc), .seq_o(seq), .illegal_op_o(ill)
   );

   int    total = 0;
   int    bad   = 0;
   int    q_addr[$];
   bit    q_ill[$];
   string q_tag[$];

   // Expected word {alu,src1,src2,reg,mem,pc,seq} per micro-address, from R2..R9.
   function automatic logic [12:0] exp_word(int a);
      case (a)
         0: return {2'b00, 1'b0, 2'b01, 2'b00, 2'b01, 2'b01, 2'b00};
         1: return {2'b00, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 2'b10};
         2: return {2'b00, 1'b1, 2'b10, 2'b00, 2'b00, 2'b00, 2'b11};
         3: return {2'b00, 1'b0, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00};
         4: return {2'b00, 1'b0, 2'b00, 2'b10, 2'b00, 2'b00, 2'b01};
         5: return {2'b00, 1'b0, 2'b00, 2'b00, 2'b11, 2'b00, 2'b01};
         6: return {2'b10, 1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00};
         7: return {2'b00, 1'b0, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01};
         8: return {2'b01, 1'b1, 2'b00, 2'b00, 2'b00, 2'b10, 2'b01};
         9: return {2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b11, 2'b01};
         default: return 13'h0;
      endcase
   endfunction

   task automatic chk(string tag, int a_exp, bit ill_exp);
      logic [12:0] w_act;
      w_act = {alu, src1, src2, rg, mem, pc, seq};
      total++;
      if (int'(upc) != a_exp || w_act !== exp_word(a_exp) || ill !== ill_exp) begin
         bad++;
         $display("FAIL %s: act upc=%0d word=%h ill=%b exp upc=%0d word=%h ill=%b",
                  tag, upc, w_act, ill, a_exp, exp_word(a_exp), ill_exp);
      end
   endtask

   task automatic push(int a, bit i, string tag);
      q_addr.push_back(a);
      q_ill.push_back(i);
      q_tag.push_back(tag);
   endtask

   task automatic cycles(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Monitor: one expected item per clock cycle out of reset.
   always @(negedge clk) begin
      if (!rst && q_addr.size() > 0) begin
         int    a;
         bit    i;
         string t;
         a = q_addr.pop_front();
         i = q_ill.pop_front();
         t = q_tag.pop_front();
         chk(t, a, i);
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset", 0, 1'b0);
      @(posedge clk);
      #1 rst = 1'b0;

      // load: R2 fetch, R3 decode, R4 dispatch, R5, R6
      opc = OP_LW;
      push(0, 0, "R2"); push(1, 0, "R3"); push(2, 0, "R4 load");
      push(3, 0, "R5 load"); push(4, 0, "R6");
      cycles(5);
      // store
      opc = OP_SW;
      push(0, 0, "R10"); push(1, 0, "R3"); push(2, 0, "R4 store"); push(5, 0, "R7");
      cycles(4);
      // register format
      opc = OP_R;
      push(0, 0, "R10"); push(1, 0, "R3"); push(6, 0, "R4 rtype"); push(7, 0, "R8");
      cycles(4);
      // branch and jump
      opc = OP_BEQ;
      push(0, 0, "R10"); push(1, 0, "R3"); push(8, 0, "R9 beq");
      cycles(3);
      opc = OP_J;
      push(0, 0, "R10"); push(1, 0, "R3"); push(9, 0, "R9 jump");
      cycles(3);
      // unmapped opcodes in table one
      opc = OP_BAD;
      push(0, 0, "R10"); push(1, 1, "R11 miss 3F");
      cycles(2);
      opc = OP_BAD2;
      push(0, 0, "R11 return"); push(1, 1, "R11 miss 01");
      cycles(2);
      opc = OP_LW;
      push(0, 0, "R11 return"); push(1, 0, "R3"); push(2, 0, "R4");
      push(3, 0, "R5"); push(4, 0, "R6");
      cycles(5);
      // table two miss: opcode changes while at micro-address 2
      opc = OP_LW;
      push(0, 0, "R10"); push(1, 0, "R3"); push(2, 1, "R12 miss");
      cycles(2);
      opc = OP_BAD;
      cycles(1);
      opc = OP_R;
      push(0, 0, "R12 return"); push(1, 0, "R3"); push(6, 0, "R4"); push(7, 0, "R8");
      cycles(4);
      // reset in the middle of a load routine
      opc = OP_LW;
      push(0, 0, "R10"); push(1, 0, "R3");
      cycles(2);
      rst = 1'b1;
      cycles(1);
      @(negedge clk);
      chk("R1 mid-run reset", 0, 1'b0);
      @(posedge clk);
      #1 rst = 1'b0;
      opc = OP_SW;
      push(0, 0, "R1 restart"); push(1, 0, "R3"); push(2, 0, "R4"); push(5, 0, "R7");
      cycles(4);
      @(negedge clk);
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule